// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block is a register target on a small valid/ready memory-mapped bus. One bus address reaches a whole set of copies of the same 32-bit register, one copy per hardware unit. Each unit is named by a group ID and an instance ID. A separate steering register holds the target group, the target instance and a broadcast bit. A write to the shared address either fans out to every live copy, when the broadcast bit is set, or lands in the one steered copy, when it is clear. A read always returns the single steered copy.

Units can be marked absent, because they are fused off or power-gated, through a per-unit enable vector. Any access steered at an absent unit, or at a group or instance number that does not exist, is terminated without an error: reads give zero and writes change nothing. A one-bit hardware semaphore at its own address lets several agents take turns at using the steering register. The steering register idles in broadcast mode. After each single-copy write the block sets the broadcast bit again by itself.

Every accepted request gets exactly one response on the next cycle. The response carries data only for reads.

Top module: `mcr_bank`

## Requirements
- R1: After reset the steering register reads 0x8000_0000 (broadcast set, group 0, instance 0), the semaphore is free and every copy holds zero.
- R2: `req_ready` is always 1. Every request with `req_valid` high gets `rsp_valid` high exactly one cycle later, and the response data is zero for writes.
- R3: A write to the shared copy address (0x010) while the broadcast bit (steering bit 31) is set stores the data in every copy whose unit is enabled.
- R4: A write to the shared copy address while the broadcast bit is clear changes only the copy at the steered group (steering bits 15:8) and instance (steering bits 7:0). Unit number = group × INSTS + instance.
- R5: A read of the shared copy address returns the steered copy, whether the broadcast bit is set or clear.
- R6: A read steered to a disabled unit, or to a group ≥ GROUPS or an instance ≥ INSTS, returns zero.
- R7: A single-copy write steered to a disabled unit is dropped, and that copy keeps its value.
- R8: A broadcast write leaves the copies of disabled units unchanged.
- R9: Reading the semaphore (0x004) returns 1 and takes it when it is free, and returns 0 when it is taken. Writing 1 frees it. Writing any other value has no effect.
- R10: A single-copy write to the shared address sets the broadcast bit again and keeps the group and instance fields. Reads and broadcast writes leave the steering register unchanged.
- R11: The unit enable vector is used in the cycle a request is accepted, so a change to it applies to the very next access.
- R12: Reads of any other address return zero, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always 1) |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes |
| unit_en | input | GROUPS*INSTS | Per-unit enable. 0 marks a fused-off or gated unit |

## Verification
The assertions assume that `req_valid` is low while reset is held, so that the first response after reset can be tied to a request. They also assume that `unit_en` changes only between clock edges, so that a copy's hold check sees the same enable value that gated the write. The bench drives every input on the falling edge, keeps the bus idle during reset, and changes the enable vector only between accesses. This lets a fused unit, a broadcast write that skips it, and re-enabling it be observed as separate transactions.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    localparam int DW    = 32;
    localparam int ID_W  = 8;

    localparam logic [31:0] OFF_STEER = 32'h0000_0000;
    localparam logic [31:0] OFF_SEMA  = 32'h0000_0004;
    localparam logic [31:0] OFF_COPY  = 32'h0000_0010;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_STEER,
        TGT_SEMA,
        TGT_COPY
    } tgt_e;

    typedef struct packed {
        logic            bcast;
        logic [ID_W-1:0] grp;
        logic [ID_W-1:0] inst;
    } steer_t;

    localparam steer_t STEER_RST = '{bcast: 1'b1, grp: '0, inst: '0};

    function automatic tgt_e decode_addr(input logic [31:0] a);
        tgt_e t;
        case (a)
            OFF_STEER: t = TGT_STEER;
            OFF_SEMA:  t = TGT_SEMA;
            OFF_COPY:  t = TGT_COPY;
            default:   t = TGT_NONE;
        endcase
        return t;
    endfunction

    function automatic steer_t unpack_steer(input logic [DW-1:0] w);
        steer_t s;
        s.bcast = w[31];
        s.grp   = w[15:8];
        s.inst  = w[7:0];
        return s;
    endfunction

    function automatic logic [DW-1:0] pack_steer(input steer_t s);
        return {s.bcast, 15'b0, s.grp, s.inst};
    endfunction

endpackage

// File: rtl/mcr_steer_sel.sv
module mcr_steer_sel
    import mcr_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int INSTS  = 4,
    parameter int UW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_steer,
    input  logic [DW-1:0] wdata,
    input  logic          rearm,
    output steer_t        steer_q,
    output logic [UW-1:0] unit_idx,
    output logic          idx_ok
);

    always_ff @(posedge clk) begin
        if (rst) begin
            steer_q <= STEER_RST;
        end else if (wr_steer) begin
            steer_q <= unpack_steer(wdata);
        end else if (rearm) begin
            steer_q.bcast <= 1'b1;
        end
    end

    always_comb begin
        idx_ok   = (32'(steer_q.grp) < 32'(GROUPS)) && (32'(steer_q.inst) < 32'(INSTS));
        unit_idx = UW'(32'(steer_q.grp) * 32'(INSTS) + 32'(steer_q.inst));
    end

    // R10
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rearm)) |-> (steer_q.bcast && $stable(steer_q.grp) && $stable(steer_q.inst)));

endmodule

// File: rtl/mcr_sema.sv
module mcr_sema
    import mcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_sema,
    input  logic          wr_sema,
    input  logic [DW-1:0] wdata,
    output logic          grant
);

    logic free_q;

    assign grant = rd_sema && free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= 1'b1;
        end else if (wr_sema && wdata == 32'h1) begin
            free_q <= 1'b1;
        end else if (grant) begin
            free_q <= 1'b0;
        end
    end

    // R9
    take_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_sema && free_q)) |-> !free_q);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(free_q) && free_q) |-> $past(wr_sema && wdata == 32'h1));

endmodule

// File: rtl/mcr_copy_array.sv
module mcr_copy_array
    import mcr_pkg::*;
#(
    parameter int UNITS = 8,
    parameter int UW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_all,
    input  logic             wr_one,
    input  logic [UW-1:0]    wr_idx,
    input  logic [DW-1:0]    wdata,
    input  logic [UNITS-1:0] unit_en,
    input  logic [UW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] copy_q [UNITS];

    for (genvar u = 0; u < UNITS; u++) begin : g_copy
        logic we;
        assign we = unit_en[u] && (wr_all || (wr_one && wr_idx == UW'(u)));

        always_ff @(posedge clk) begin
            if (rst) begin
                copy_q[u] <= '0;
            end else if (we) begin
                copy_q[u] <= wdata;
            end
        end

        // R7 R8
        fused_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(unit_en[u])) |-> $stable(copy_q[u]));
    end

    always_comb begin
        rd_data = '0;
        for (int u = 0; u < UNITS; u++) begin
            if (rd_idx == UW'(u)) rd_data = copy_q[u];
        end
    end

endmodule

// File: rtl/mcr_bank.sv
module mcr_bank
    import mcr_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int INSTS  = 4,
    parameter int AW     = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    output logic                     req_ready,
    output logic                     rsp_valid,
    output logic [DW-1:0]            rsp_rdata,
    input  logic [GROUPS*INSTS-1:0]  unit_en
);

    localparam int UNITS = GROUPS * INSTS;
    localparam int UW    = (UNITS > 1) ? $clog2(UNITS) : 1;

    tgt_e          tgt;
    steer_t        steer_q;
    logic [UW-1:0] unit_idx;
    logic          idx_ok;
    logic          live;
    logic          wr_steer, wr_sema, rd_sema, wr_copy;
    logic          wr_all, wr_one, rearm, grant;
    logic [DW-1:0] copy_rd, rd_mux;

    assign req_ready = 1'b1;

    always_comb begin
        tgt      = decode_addr(32'(req_addr));
        wr_steer = req_valid &&  req_write && tgt == TGT_STEER;
        wr_sema  = req_valid &&  req_write && tgt == TGT_SEMA;
        rd_sema  = req_valid && !req_write && tgt == TGT_SEMA;
        wr_copy  = req_valid &&  req_write && tgt == TGT_COPY;
        live     = idx_ok && unit_en[unit_idx];
        wr_all   = wr_copy &&  steer_q.bcast;
        wr_one   = wr_copy && !steer_q.bcast && live;
        rearm    = wr_copy && !steer_q.bcast;
    end

    mcr_steer_sel #(.GROUPS(GROUPS), .INSTS(INSTS), .UW(UW)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .wr_steer (wr_steer),
        .wdata    (req_wdata),
        .rearm    (rearm),
        .steer_q  (steer_q),
        .unit_idx (unit_idx),
        .idx_ok   (idx_ok)
    );

    mcr_sema u_sema (
        .clk     (clk),
        .rst     (rst),
        .rd_sema (rd_sema),
        .wr_sema (wr_sema),
        .wdata   (req_wdata),
        .grant   (grant)
    );

    mcr_copy_array #(.UNITS(UNITS), .UW(UW)) u_copies (
        .clk     (clk),
        .rst     (rst),
        .wr_all  (wr_all),
        .wr_one  (wr_one),
        .wr_idx  (unit_idx),
        .wdata   (req_wdata),
        .unit_en (unit_en),
        .rd_idx  (unit_idx),
        .rd_data (copy_rd)
    );

    always_comb begin
        case (tgt)
            TGT_STEER: rd_mux = pack_steer(steer_q);
            TGT_SEMA:  rd_mux = {31'b0, grant};
            TGT_COPY:  rd_mux = live ? copy_rd : '0;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    // R2
    one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R2
    wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && req_write)) |-> (rsp_rdata == '0));

    // R6
    dead_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid && !req_write && tgt == TGT_COPY && !live))
            |-> (rsp_rdata == '0));

    // R2
    ready_chk: assert property (@(posedge clk) disable iff (rst) req_ready);

endmodule

// File: tb/sim_mcr_bank.sv
module sim_mcr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int GROUPS = 2;
    localparam int INSTS  = 4;
    localparam int AW     = 12;
    localparam logic [11:0] A_STEER = 12'h000;
    localparam logic [11:0] A_SEMA  = 12'h004;
    localparam logic [11:0] A_COPY  = 12'h010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [GROUPS*INSTS-1:0] unit_en = '1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcr_bank #(.GROUPS(GROUPS), .INSTS(INSTS), .AW(AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .unit_en   (unit_en)
    );

    function automatic logic [31:0] sw(input logic b, input int g, input int i);
        return {b, 15'b0, 8'(g), 8'(i)};
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] r, output logic v);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        v = rsp_valid;
        r = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] r;
        logic v;
        access(1'b1, a, d, r, v);
        chk({31'b0, v}, 32'h1, "R2 write response valid");
        chk(r, 32'h0, "R2 write response data");
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r);
        logic v;
        access(1'b0, a, 32'h0, r, v);
        chk({31'b0, v}, 32'h1, "R2 read response valid");
    endtask

    task automatic t_reset;
        logic [31:0] r;
        chk({31'b0, req_ready}, 32'h1, "R2 ready high");
        chk({31'b0, rsp_valid}, 32'h0, "R1 no response after reset");
        rd(A_STEER, r);
        chk(r, 32'h8000_0000, "R1 steering reset value");
        rd(A_COPY, r);
        chk(r, 32'h0, "R1 copy reset value");
    endtask

    task automatic t_broadcast;
        logic [31:0] r;
        wr(A_COPY, 32'hA5A5_0001);
        for (int g = 0; g < GROUPS; g++) begin
            for (int i = 0; i < INSTS; i++) begin
                wr(A_STEER, sw(1'b1, g, i));
                rd(A_COPY, r);
                chk(r, 32'hA5A5_0001, "R3 broadcast reached copy");
            end
        end
    endtask

    task automatic t_unicast;
        logic [31:0] r;
        wr(A_STEER, sw(1'b0, 1, 2));
        wr(A_COPY, 32'h0000_1234);
        rd(A_STEER, r);
        chk(r, 32'h8000_0102, "R10 broadcast bit rearmed");
        rd(A_COPY, r);
        chk(r, 32'h0000_1234, "R5 read with broadcast set");
        wr(A_STEER, sw(1'b0, 1, 2));
        rd(A_COPY, r);
        chk(r, 32'h0000_1234, "R5 read with broadcast clear");
        rd(A_STEER, r);
        chk(r, 32'h0000_0102, "R10 read does not rearm");
        wr(A_STEER, sw(1'b1, 1, 1));
        rd(A_COPY, r);
        chk(r, 32'hA5A5_0001, "R4 neighbour copy untouched");
        wr(A_STEER, sw(1'b1, 0, 2));
        rd(A_COPY, r);
        chk(r, 32'hA5A5_0001, "R4 other group untouched");
    endtask

    task automatic t_fused;
        logic [31:0] r;
        unit_en = 8'hF7;
        wr(A_STEER, sw(1'b1, 0, 3));
        rd(A_COPY, r);
        chk(r, 32'h0, "R6 read of disabled unit");
        wr(A_STEER, sw(1'b0, 0, 3));
        wr(A_COPY, 32'h0000_DEAD);
        wr(A_STEER, sw(1'b1, 0, 0));
        wr(A_COPY, 32'h7777_0000);
        rd(A_COPY, r);
        chk(r, 32'h7777_0000, "R3 live copy updated");
        wr(A_STEER, sw(1'b1, 1, 3));
        rd(A_COPY, r);
        chk(r, 32'h7777_0000, "R3 other live copy updated");
        unit_en = 8'hFF;
        wr(A_STEER, sw(1'b1, 0, 3));
        rd(A_COPY, r);
        chk(r, 32'hA5A5_0001, "R7 R8 R11 disabled copy kept value");
        unit_en = 8'hF7;
        rd(A_COPY, r);
        chk(r, 32'h0, "R11 disable applies at next access");
        unit_en = 8'hFF;
        wr(A_STEER, sw(1'b1, 2, 0));
        rd(A_COPY, r);
        chk(r, 32'h0, "R6 group out of range");
        wr(A_STEER, sw(1'b1, 0, 4));
        rd(A_COPY, r);
        chk(r, 32'h0, "R6 instance out of range");
        wr(A_STEER, sw(1'b1, 0, 3));
    endtask

    task automatic t_sema;
        logic [31:0] r;
        rd(A_SEMA, r);
        chk(r, 32'h1, "R9 first read acquires");
        rd(A_SEMA, r);
        chk(r, 32'h0, "R9 held semaphore reads 0");
        wr(A_SEMA, 32'h2);
        rd(A_SEMA, r);
        chk(r, 32'h0, "R9 non-one write ignored");
        wr(A_SEMA, 32'h1);
        rd(A_SEMA, r);
        chk(r, 32'h1, "R9 reacquire after release");
        wr(A_SEMA, 32'h1);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, r);
        chk(r, 32'h0, "R12 unmapped read zero");
        rd(A_STEER, r);
        chk(r, 32'h8000_0003, "R12 steering unchanged");
        rd(A_COPY, r);
        chk(r, 32'hA5A5_0001, "R12 copy unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_broadcast();
        t_unicast();
        t_fused();
        t_sema();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule